// File: doc/BRIEF.md
# Tamper Pin Debouncer

This block watches two tamper-capable input pins and decides when either one has been held at its active level for enough consecutive ticks of a slow RTC-derived clock enable. A pin that passes this filter produces one tamper event. The event sets a sticky per-pin status flag and an interrupt that stays high while any flag is set. It can also produce three single-cycle pulses: a wake-up request, a command to clear the lower half of a backup register bank, and, for pin 1 only, a timestamp capture request.

A shared 3-bit period code sets the debounce length for both pins, and code 0 turns both filters off. Each pin has its own connect enable, active-level bit and wake-up enable. Pin 1 also has two disable bits of its own, one for the backup clear and one for the timestamp. Status flags are cleared by a one-cycle read strobe.

Top module: `tamper_lpdb`

## Requirements
- R1: When `period_code` is 0, neither pin produces an event and both debounce counts are held at zero.
- R2: For `period_code` n in 1..7, an event occurs on the (n+1)-th consecutive tick that samples the pin active. For example, code 1 needs 2 ticks and code 7 needs 8 ticks. The pulses appear in the clock cycle after that tick's edge.
- R3: The debounce count changes only on cycles where `rtc_tick` is 1. A tick that samples the pin inactive restarts the count. A pin that is inactive only between ticks does not restart it.
- R4: A pin whose `pin_conn[i]` bit is 0 never produces an event.
- R5: `pin_pol[i]` sets the active level of pin i: 1 means high is active, 0 means low is active.
- R6: `status_flag[i]` is set by an event on pin i and stays set until a cycle with `status_rd` = 1 clears it. An event in the same cycle as the read wins. `irq` is 1 while either flag is 1.
- R7: `wake_req` pulses for an event on pin i only if `wake_en[i]` is 1.
- R8: `bkup_clr` pulses when `clr_en` is 1 and one of these holds: pin 0 has an event, or pin 1 has an event while `pin1_clr_dis` is 0.
- R9: `ts_req` pulses on a pin-1 event unless `pin1_ts_dis` is 1. Pin 0 never causes it.
- R10: Each event gives pulses lasting exactly one cycle. A pin that stays active on later ticks produces no further event until a tick samples it inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rtc_tick | input | 1 | One-cycle enable per RTC output period |
| pin_in | input | 2 | Synchronized tamper pin levels |
| pin_pol | input | 2 | Active level per pin (1 = high) |
| pin_conn | input | 2 | Connect enable per pin |
| wake_en | input | 2 | Wake-up enable per pin |
| period_code | input | 3 | Debounce code: 0 = off, n = n+1 ticks |
| clr_en | input | 1 | Allow backup-bank clear on events |
| pin1_clr_dis | input | 1 | Block backup clear from pin 1 |
| pin1_ts_dis | input | 1 | Block timestamp request from pin 1 |
| status_rd | input | 1 | Status read strobe, clears flags |
| status_flag | output | 2 | Sticky event flag per pin |
| irq | output | 1 | High while any flag is set |
| wake_req | output | 1 | Wake-up request pulse |
| bkup_clr | output | 1 | Clear pulse for lower backup half |
| ts_req | output | 1 | Timestamp capture pulse (pin 1) |

## Verification
The assertions assume that `rtc_tick` is a one-cycle strobe sampled on the same clock as the pins. They also assume that the configuration inputs stay stable for at least one cycle before a tick whose result is checked. The off-period property additionally requires `period_code` to have been 0 for the previous cycle. The directed tasks change pins and configuration only at falling edges and between ticks. They leave one idle cycle after every tick, so each event is observed in isolation.

// File: rtl/tdb_pkg.sv
// Package: shared sizing helpers for the tamper debouncer.
// Assumes the period code maps code n to n+1 required ticks.
package tdb_pkg;
    localparam int NUM_PINS = 2;

    // Width of a count able to hold the longest target (2**pw ticks).
    function automatic int cnt_width(input int pw);
        return pw + 1;
    endfunction
endpackage

// File: rtl/tdb_pin_counter.sv
// Module: per-pin debounce counter.
// Counts consecutive ticks that sample the pin active and raises a
// one-cycle event when the count first reaches the target.
// Assumes tick is a single-cycle strobe; target is 0 only when disabled.
module tdb_pin_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             enable,
    input  logic             active,
    input  logic [CNT_W-1:0] target,
    output logic             evt
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;

    // Next count value, used for the reach test.
    always_comb cnt_nxt = cnt + CNT_W'(1);

    // Advance on active ticks, restart on inactive ticks or when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            evt <= 1'b0;
        end else begin
            evt <= 1'b0;
            if (!enable) begin
                cnt <= '0;
            end else if (tick) begin
                if (!active) begin
                    cnt <= '0;
                end else if (cnt < target) begin
                    cnt <= cnt_nxt;
                    evt <= (cnt_nxt == target);
                end
            end
        end
    end
endmodule

// File: rtl/tdb_route.sv
// Module: event routing and sticky status.
// Turns per-pin events into status flags, interrupt and action pulses.
// Assumes evt bits are single-cycle; pin 1 owns the disable bits.
module tdb_route #(
    parameter int PINS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] evt,
    input  logic [PINS-1:0] wake_en,
    input  logic            clr_en,
    input  logic            pin1_clr_dis,
    input  logic            pin1_ts_dis,
    input  logic            status_rd,
    output logic [PINS-1:0] status_flag,
    output logic            irq,
    output logic            wake_req,
    output logic            bkup_clr,
    output logic            ts_req
);
    // Sticky flags: a read clears, a new event sets and wins.
    always_ff @(posedge clk) begin
        if (!rst_n) status_flag <= '0;
        else        status_flag <= (status_flag & ~{PINS{status_rd}}) | evt;
    end

    // Interrupt level and action pulses.
    always_comb begin
        irq      = |status_flag;
        wake_req = |(evt & wake_en);
        bkup_clr = clr_en && (evt[0] || (evt[1] && !pin1_clr_dis));
        ts_req   = evt[1] && !pin1_ts_dis;
    end
endmodule

// File: rtl/tamper_lpdb.sv
// Module: top of the tamper pin debouncer.
// Decodes the period code, applies per-pin polarity and connect
// enables, and feeds one counter per pin into the router.
// Assumes pin_in is already synchronized to clk.
module tamper_lpdb
    import tdb_pkg::*;
#(
    parameter int PERIOD_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rtc_tick,
    input  logic [1:0]          pin_in,
    input  logic [1:0]          pin_pol,
    input  logic [1:0]          pin_conn,
    input  logic [1:0]          wake_en,
    input  logic [PERIOD_W-1:0] period_code,
    input  logic                clr_en,
    input  logic                pin1_clr_dis,
    input  logic                pin1_ts_dis,
    input  logic                status_rd,
    output logic [1:0]          status_flag,
    output logic                irq,
    output logic                wake_req,
    output logic                bkup_clr,
    output logic                ts_req
);
    localparam int CNT_W = cnt_width(PERIOD_W);

    logic [CNT_W-1:0]    target;
    logic                lpdb_on;
    logic [NUM_PINS-1:0] active;
    logic [NUM_PINS-1:0] evt;

    // Required tick count and global enable from the period code.
    always_comb begin
        lpdb_on = (period_code != '0);
        target  = lpdb_on ? (CNT_W'(period_code) + CNT_W'(1)) : '0;
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        // Active when the pin level matches its polarity bit.
        always_comb active[i] = ~(pin_in[i] ^ pin_pol[i]);

        tdb_pin_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (rtc_tick),
            .enable (lpdb_on && pin_conn[i]),
            .active (active[i]),
            .target (target),
            .evt    (evt[i])
        );
    end

    tdb_route #(.PINS(NUM_PINS)) u_route (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt          (evt),
        .wake_en      (wake_en),
        .clr_en       (clr_en),
        .pin1_clr_dis (pin1_clr_dis),
        .pin1_ts_dis  (pin1_ts_dis),
        .status_rd    (status_rd),
        .status_flag  (status_flag),
        .irq          (irq),
        .wake_req     (wake_req),
        .bkup_clr     (bkup_clr),
        .ts_req       (ts_req)
    );
endmodule

// File: rtl/tdb_checker.sv
// Module: property checker bound to the tamper debouncer top.
// Assumes rtc_tick is a one-cycle strobe on clk.
module tdb_checker #(
    parameter int PERIOD_W = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rtc_tick,
    input logic [1:0]          wake_en,
    input logic [PERIOD_W-1:0] period_code,
    input logic                clr_en,
    input logic                pin1_ts_dis,
    input logic                status_rd,
    input logic [1:0]          status_flag,
    input logic                wake_req,
    input logic                bkup_clr,
    input logic                ts_req
);
    assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (period_code == '0 && $past(period_code) == '0) |-> !(wake_req || bkup_clr || ts_req));

    assert_pulse_after_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req || bkup_clr || ts_req) |-> $past(rtc_tick));

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !status_rd |=> (($past(status_flag) & ~status_flag) == 2'b00));

    assert_wake_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> (wake_en != 2'b00));

    assert_clr_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bkup_clr |-> clr_en);

    assert_ts_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ts_req |-> !pin1_ts_dis);

    assert_ts_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ts_req |=> !ts_req);

    assert_clr_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bkup_clr |=> !bkup_clr);
endmodule

bind tamper_lpdb tdb_checker #(.PERIOD_W(PERIOD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rtc_tick    (rtc_tick),
    .wake_en     (wake_en),
    .period_code (period_code),
    .clr_en      (clr_en),
    .pin1_ts_dis (pin1_ts_dis),
    .status_rd   (status_rd),
    .status_flag (status_flag),
    .wake_req    (wake_req),
    .bkup_clr    (bkup_clr),
    .ts_req      (ts_req)
);

// File: tb/tb_tamper_lpdb.sv
// Directed bench for the tamper debouncer; one task per scenario.
module tb_tamper_lpdb;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rtc_tick = 1'b0;
    logic [1:0] pin_in = 2'b00;
    logic [1:0] pin_pol = 2'b11;
    logic [1:0] pin_conn = 2'b00;
    logic [1:0] wake_en = 2'b00;
    logic [2:0] period_code = 3'd0;
    logic       clr_en = 1'b0;
    logic       pin1_clr_dis = 1'b0;
    logic       pin1_ts_dis = 1'b0;
    logic       status_rd = 1'b0;
    logic [1:0] status_flag;
    logic       irq, wake_req, bkup_clr, ts_req;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tamper_lpdb dut (
        .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .pin_in(pin_in),
        .pin_pol(pin_pol), .pin_conn(pin_conn), .wake_en(wake_en),
        .period_code(period_code), .clr_en(clr_en),
        .pin1_clr_dis(pin1_clr_dis), .pin1_ts_dis(pin1_ts_dis),
        .status_rd(status_rd), .status_flag(status_flag), .irq(irq),
        .wake_req(wake_req), .bkup_clr(bkup_clr), .ts_req(ts_req)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Pulses packed as {wake_req, bkup_clr, ts_req}.
    function automatic logic [7:0] pulses();
        return {5'd0, wake_req, bkup_clr, ts_req};
    endfunction

    // One tick with given pin levels; returns in the cycle after the edge.
    task automatic tick(input logic [1:0] pins);
        @(negedge clk); pin_in = pins; rtc_tick = 1'b1;
        @(negedge clk); rtc_tick = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic rd();
        @(negedge clk); status_rd = 1'b1;
        @(negedge clk); status_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R6 reset flags", {6'd0, status_flag}, 8'd0);
        chk("R6 reset irq", {7'd0, irq}, 8'd0);
        chk("R10 reset pulses", pulses(), 8'd0);
    endtask

    task automatic t_length();
        period_code = 3'd2; pin_conn = 2'b11; pin_pol = 2'b11;
        wake_en = 2'b01; clr_en = 1'b1;
        tick(2'b01); chk("R2 tick1 quiet", pulses(), 8'd0);
        tick(2'b01); chk("R2 tick2 quiet", pulses(), 8'd0);
        tick(2'b01); chk("R2 R7 R8 tick3 event", pulses(), 8'b110);
        chk("R6 flag not yet", {6'd0, status_flag}, 8'd0);
        idle();
        chk("R6 flag set", {6'd0, status_flag}, 8'b01);
        chk("R6 irq set", {7'd0, irq}, 8'd1);
        chk("R10 pulse ended", pulses(), 8'd0);
        tick(2'b01); chk("R10 no repeat while active", pulses(), 8'd0);
        rd(); chk("R6 read clears", {6'd0, status_flag}, 8'd0);
        chk("R6 irq cleared", {7'd0, irq}, 8'd0);
        tick(2'b00); idle();
    endtask

    task automatic t_restart();
        period_code = 3'd1; wake_en = 2'b00; clr_en = 1'b1;
        tick(2'b01); tick(2'b00);
        tick(2'b01); chk("R3 restart after inactive tick", pulses(), 8'd0);
        @(negedge clk); pin_in = 2'b00;
        @(negedge clk); pin_in = 2'b01;
        tick(2'b01); chk("R3 off-tick low ignored", pulses(), 8'b010);
        tick(2'b00); rd();
    endtask

    task automatic t_disabled();
        period_code = 3'd0;
        for (int k = 0; k < 10; k++) begin
            tick(2'b11);
            if (pulses() != 0) chk("R1 code0 quiet", pulses(), 8'd0);
        end
        chk("R1 code0 no flag", {6'd0, status_flag}, 8'd0);
        period_code = 3'd7; pin_conn = 2'b00;
        for (int k = 0; k < 10; k++) begin
            tick(2'b11);
            if (pulses() != 0) chk("R4 unconnected quiet", pulses(), 8'd0);
        end
        chk("R4 unconnected no flag", {6'd0, status_flag}, 8'd0);
        pin_conn = 2'b01; tick(2'b00);
        for (int k = 0; k < 7; k++) tick(2'b01);
        chk("R2 code7 tick7 quiet", pulses(), 8'd0);
        tick(2'b01); chk("R2 code7 tick8 event", pulses(), 8'b010);
        tick(2'b00); rd();
    endtask

    task automatic t_pin1();
        period_code = 3'd1; pin_conn = 2'b10; pin_pol = 2'b01;
        clr_en = 1'b1; wake_en = 2'b10;
        pin1_clr_dis = 1'b0; pin1_ts_dis = 1'b0;
        tick(2'b10); tick(2'b10);
        chk("R5 high ignored on low-active pin", pulses(), 8'd0);
        tick(2'b00);
        tick(2'b00); chk("R5 R7 R8 R9 pin1 event", pulses(), 8'b111);
        idle(); chk("R6 pin1 flag", {6'd0, status_flag}, 8'b10);
        tick(2'b10);
        pin1_clr_dis = 1'b1; pin1_ts_dis = 1'b1; wake_en = 2'b01;
        tick(2'b00);
        tick(2'b00); chk("R8 R9 R7 pin1 gated", pulses(), 8'd0);
        tick(2'b10); rd();
        chk("R9 flag cleared", {6'd0, status_flag}, 8'd0);
        pin1_clr_dis = 1'b0; pin1_ts_dis = 1'b0;
    endtask

    task automatic t_collide();
        period_code = 3'd1; pin_conn = 2'b01; pin_pol = 2'b11;
        tick(2'b01); tick(2'b01);
        status_rd = 1'b1;
        @(negedge clk); status_rd = 1'b0;
        chk("R6 event wins over read", {6'd0, status_flag}, 8'b01);
        rd(); chk("R6 later read clears", {6'd0, status_flag}, 8'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_length();
        t_restart();
        t_disabled();
        t_pin1();
        t_collide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++; failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule